// File: doc/BRIEF.md
# Serial Memory Write-Protection Arbiter

This block sits behind the bit-level front end of a two-wire serial memory. It decides, phase by phase, whether the memory acknowledges a write and whether the write may reach the array. It also holds the two lower-half protection flags. The front end hands it each received byte as a one-cycle strobe, together with the decoded fields. These are the device-address byte (4-bit device code, the three received select bits, the R/W bit, and a flag meaning "A0 is held at high voltage"), the word-address byte, the data bytes and the stop condition. In the next cycle the block answers with a one-cycle acknowledge enable for that phase. For memory data bytes it also answers with a write-allowed pulse.

Protection is either total or for the lower half. When the write-protect pin is high, the whole array is protected. Software protection covers only the lower half of the address space (most significant word-address bit = 0). It comes in two forms. The reversible flag can be set and cleared by command, and it is lost at power-up. The permanent flag can only be set. It survives power-up and is cleared only by the separate nonvolatile-erase input, which models the factory state. Protection commands use the byte-write framing with device code 0110. The word-address byte and the data byte of these commands carry no meaning. A command takes effect only at the stop condition that follows its data byte.

Top module: `wpc_top`

## Requirements
- R1: A device-address byte with code 1010 is acknowledged when its select bits {A2,A1,A0} (sel[2:0]) equal the strapped pin_sel value. Any other code and select combination that is not a valid protection command gets no acknowledge.
- R2: While wp is high, memory data bytes get no acknowledge and no write-allowed pulse. This holds at every address.
- R3: While wp is high, every protection command (code 0110, R/W = 0) is refused at the device-address byte.
- R4: Set-reversible is code 0110, R/W = 0, A0 at high voltage and sel[2:1] = 00. Its word-address and data bytes are acknowledged. After the stop, data bytes to addresses 00h–7Fh are refused and addresses 80h–FFh stay writable.
- R5: Clear-reversible is code 0110, R/W = 0, A0 at high voltage and sel[2:1] = 01. After its stop, the lower half is writable again, unless the permanent flag is set.
- R6: Set-permanent is code 0110, R/W = 0, no high voltage and sel equal to pin_sel. After its stop, the lower half stays protected. A clear command, a toggle of wp or a power-up (rst_n) does not remove this protection.
- R7: Once the permanent flag is set, no device-address byte with code 0110 is acknowledged.
- R8: A status query (code 0110, R/W = 1) is acknowledged only at its device-address byte. The reversible queries (high voltage with sel[2:1] = 00 or 01) are acknowledged only while the reversible flag is clear. The permanent query (no high voltage, sel = pin_sel) is acknowledged only while the permanent flag is clear.
- R9: A power-up (rst_n low) clears the reversible flag. The permanent flag is cleared only by nv_erase_n low.
- R10: A protection command ended by a stop before its data byte leaves both flags unchanged.
- R11: After reset all acknowledge and write-allowed outputs are low. Each one is a single-cycle pulse in the cycle after the strobe it answers. The word-address byte of an accepted memory write is always acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset (clears the reversible flag and the sequencing) |
| nv_erase_n | input | 1 | Active-low erase of the nonvolatile permanent flag |
| dev_stb | input | 1 | Device-address byte received |
| dev_code | input | 4 | Device code of that byte |
| dev_sel | input | 3 | Received select bits {A2,A1,A0} |
| dev_rw | input | 1 | Received R/W bit (1 = read) |
| a0_hv | input | 1 | A0 held at high voltage during that byte |
| pin_sel | input | 3 | Strapped select pins {A2,A1,A0} |
| wp | input | 1 | Write-protect pin |
| addr_stb | input | 1 | Word-address byte received |
| word_addr | input | 8 | Received word address |
| data_stb | input | 1 | Data byte received |
| stop_stb | input | 1 | Stop condition detected |
| ack_dev | output | 1 | Acknowledge the device-address byte |
| ack_addr | output | 1 | Acknowledge the word-address byte |
| ack_data | output | 1 | Acknowledge the data byte |
| wr_allow | output | 1 | Data byte may be written to the array |

## Verification
The assertions assume a well-formed front end. Strobes are one cycle long, at most one strobe is high in any cycle, and wp stays steady from the device-address byte to the stop of a write. The directed stimulus drives every strobe as a single-cycle pulse with idle cycles between them. It changes wp only between transactions, so a refusal seen at the data phase always comes from the wp level the command started with.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MEM_ADDR,
        PH_MEM_DATA,
        PH_PROT_ADDR,
        PH_PROT_DATA,
        PH_PROT_ARM
    } phase_e;

    typedef enum logic [1:0] {
        PC_NONE,
        PC_SET_R,
        PC_CLR_R,
        PC_SET_P
    } pcmd_e;

    typedef struct packed {
        logic  acc;
        logic  is_mem;
        logic  rd;
        pcmd_e pcmd;
    } dec_t;

endpackage

// File: rtl/wpc_dev_decode.sv
module wpc_dev_decode
    import wpc_pkg::*;
#(
    parameter logic [3:0] MEM_CODE  = 4'b1010,
    parameter logic [3:0] PROT_CODE = 4'b0110
) (
    input  logic [3:0] code,
    input  logic [2:0] sel,
    input  logic       rw,
    input  logic       hv,
    input  logic [2:0] pin_sel,
    input  logic       wp,
    input  logic       rswp,
    input  logic       pswp,
    output dec_t       dec
);
    logic  pin_match;
    logic  mem_hit;
    logic  prot_hit;
    pcmd_e kind;

    always_comb begin
        pin_match = (sel == pin_sel);
        mem_hit   = (code == MEM_CODE) && pin_match;
        prot_hit  = (code == PROT_CODE);

        if (hv && sel[2:1] == 2'b00)      kind = PC_SET_R;
        else if (hv && sel[2:1] == 2'b01) kind = PC_CLR_R;
        else if (!hv && pin_match)        kind = PC_SET_P;
        else                              kind = PC_NONE;

        dec.is_mem = mem_hit;
        dec.rd     = rw;
        dec.pcmd   = kind;
        dec.acc    = 1'b0;
        if (mem_hit) begin
            dec.acc = 1'b1;
        end else if (prot_hit && !pswp && kind != PC_NONE) begin
            if (!rw)                 dec.acc = !wp;
            else if (kind == PC_SET_P) dec.acc = !pswp;
            else                     dec.acc = !rswp;
        end
    end

endmodule

// File: rtl/wpc_flags.sv
module wpc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_erase_n,
    input  logic set_r,
    input  logic clr_r,
    input  logic set_p,
    output logic rswp,
    output logic pswp
);
    logic rswp_d, rswp_q;
    logic pswp_d, pswp_q;

    always_comb begin
        rswp_d = rswp_q;
        if (set_r)      rswp_d = 1'b1;
        else if (clr_r) rswp_d = 1'b0;
        pswp_d = pswp_q | set_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rswp_q <= 1'b0;
        else        rswp_q <= rswp_d;
    end

    always_ff @(posedge clk or negedge nv_erase_n) begin
        if (!nv_erase_n) pswp_q <= 1'b0;
        else             pswp_q <= pswp_d;
    end

    assign rswp = rswp_q;
    assign pswp = pswp_q;

endmodule

// File: rtl/wpc_write_gate.sv
module wpc_write_gate #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp,
    input  logic              rswp,
    input  logic              pswp,
    output logic              allow
);
    localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);

    logic lower;

    always_comb begin
        lower = (addr < HALF);
        allow = !wp && !(lower && (rswp || pswp));
    end

endmodule

// File: rtl/wpc_top.sv
module wpc_top
    import wpc_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter logic [3:0] MEM_CODE  = 4'b1010,
    parameter logic [3:0] PROT_CODE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_erase_n,
    input  logic              dev_stb,
    input  logic [3:0]        dev_code,
    input  logic [2:0]        dev_sel,
    input  logic              dev_rw,
    input  logic              a0_hv,
    input  logic [2:0]        pin_sel,
    input  logic              wp,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              data_stb,
    input  logic              stop_stb,
    output logic              ack_dev,
    output logic              ack_addr,
    output logic              ack_data,
    output logic              wr_allow
);
    typedef struct packed {
        phase_e            ph;
        pcmd_e             cmd;
        logic [ADDR_W-1:0] addr;
        logic              ack_dev;
        logic              ack_addr;
        logic              ack_data;
        logic              wr;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;
    logic rswp, pswp;
    logic allow;
    logic set_r, clr_r, set_p;

    wpc_dev_decode #(
        .MEM_CODE (MEM_CODE),
        .PROT_CODE(PROT_CODE)
    ) dec_i (
        .code   (dev_code),
        .sel    (dev_sel),
        .rw     (dev_rw),
        .hv     (a0_hv),
        .pin_sel(pin_sel),
        .wp     (wp),
        .rswp   (rswp),
        .pswp   (pswp),
        .dec    (dec)
    );

    wpc_write_gate #(.ADDR_W(ADDR_W)) gate_i (
        .addr (st_q.addr),
        .wp   (wp),
        .rswp (rswp),
        .pswp (pswp),
        .allow(allow)
    );

    wpc_flags flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_erase_n(nv_erase_n),
        .set_r     (set_r),
        .clr_r     (clr_r),
        .set_p     (set_p),
        .rswp      (rswp),
        .pswp      (pswp)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack_dev  = 1'b0;
        st_d.ack_addr = 1'b0;
        st_d.ack_data = 1'b0;
        st_d.wr       = 1'b0;
        set_r         = 1'b0;
        clr_r         = 1'b0;
        set_p         = 1'b0;

        if (stop_stb) begin
            if (st_q.ph == PH_PROT_ARM) begin
                set_r = (st_q.cmd == PC_SET_R);
                clr_r = (st_q.cmd == PC_CLR_R);
                set_p = (st_q.cmd == PC_SET_P);
            end
            st_d.ph = PH_IDLE;
        end else if (dev_stb) begin
            st_d.ack_dev = dec.acc;
            st_d.cmd     = dec.pcmd;
            if (!dec.acc || dec.rd) st_d.ph = PH_IDLE;
            else if (dec.is_mem)    st_d.ph = PH_MEM_ADDR;
            else                    st_d.ph = PH_PROT_ADDR;
        end else if (addr_stb) begin
            case (st_q.ph)
                PH_MEM_ADDR: begin
                    st_d.ack_addr = 1'b1;
                    st_d.addr     = word_addr;
                    st_d.ph       = PH_MEM_DATA;
                end
                PH_PROT_ADDR: begin
                    st_d.ack_addr = 1'b1;
                    st_d.ph       = PH_PROT_DATA;
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end else if (data_stb) begin
            case (st_q.ph)
                PH_MEM_DATA: begin
                    st_d.ack_data = allow;
                    st_d.wr       = allow;
                end
                PH_PROT_DATA: begin
                    st_d.ack_data = 1'b1;
                    st_d.ph       = PH_PROT_ARM;
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cmd: PC_NONE, addr: '0,
                      ack_dev: 1'b0, ack_addr: 1'b0, ack_data: 1'b0, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_dev  = st_q.ack_dev;
    assign ack_addr = st_q.ack_addr;
    assign ack_data = st_q.ack_data;
    assign wr_allow = st_q.wr;

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter logic [3:0] PROT_CODE = 4'b0110
) (
    input logic       clk,
    input logic       rst_n,
    input logic       nv_erase_n,
    input logic       dev_stb,
    input logic [3:0] dev_code,
    input logic       wp,
    input logic       data_stb,
    input logic       ack_dev,
    input logic       ack_data,
    input logic       wr_allow,
    input logic       pswp
);

    assert_wp_blocks_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && wp) |=> (!ack_data && !wr_allow));

    assert_write_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> ack_data);

    assert_perm_sticky_R6: assert property (@(posedge clk) disable iff (!nv_erase_n)
        pswp |=> pswp);

    assert_perm_hides_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_stb && dev_code == PROT_CODE && pswp) |=> !ack_dev);

    assert_dev_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_dev |-> $past(dev_stb));

    assert_data_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_data |-> $past(data_stb));

endmodule

bind wpc_top wpc_checker #(.PROT_CODE(PROT_CODE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_erase_n(nv_erase_n),
    .dev_stb   (dev_stb),
    .dev_code  (dev_code),
    .wp        (wp),
    .data_stb  (data_stb),
    .ack_dev   (ack_dev),
    .ack_data  (ack_data),
    .wr_allow  (wr_allow),
    .pswp      (pswp)
);

// File: tb/wpc_top_tb_top.sv
module wpc_top_tb_top;
    localparam logic [3:0] MEMC  = 4'b1010;
    localparam logic [3:0] PROTC = 4'b0110;
    localparam logic [2:0] PIN   = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_erase_n = 1'b0;
    logic       dev_stb = 1'b0;
    logic [3:0] dev_code = '0;
    logic [2:0] dev_sel = '0;
    logic       dev_rw = 1'b0;
    logic       a0_hv = 1'b0;
    logic [2:0] pin_sel = PIN;
    logic       wp = 1'b0;
    logic       addr_stb = 1'b0;
    logic [7:0] word_addr = '0;
    logic       data_stb = 1'b0;
    logic       stop_stb = 1'b0;
    logic       ack_dev, ack_addr, ack_data, wr_allow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wpc_top dut_i (
        .clk(clk), .rst_n(rst_n), .nv_erase_n(nv_erase_n),
        .dev_stb(dev_stb), .dev_code(dev_code), .dev_sel(dev_sel),
        .dev_rw(dev_rw), .a0_hv(a0_hv), .pin_sel(pin_sel), .wp(wp),
        .addr_stb(addr_stb), .word_addr(word_addr), .data_stb(data_stb),
        .stop_stb(stop_stb), .ack_dev(ack_dev), .ack_addr(ack_addr),
        .ack_data(ack_data), .wr_allow(wr_allow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_dev(input logic [3:0] code, input logic [2:0] sel,
                            input logic rw, input logic hv, output logic ack);
        @(negedge clk);
        dev_code = code; dev_sel = sel; dev_rw = rw; a0_hv = hv; dev_stb = 1'b1;
        @(negedge clk);
        dev_stb = 1'b0; a0_hv = 1'b0;
        ack = ack_dev;
    endtask

    task automatic send_addr(input logic [7:0] a, output logic ack);
        @(negedge clk);
        word_addr = a; addr_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        ack = ack_addr;
    endtask

    task automatic send_data(output logic ack, output logic wr);
        @(negedge clk);
        data_stb = 1'b1;
        @(negedge clk);
        data_stb = 1'b0;
        ack = ack_data;
        wr = wr_allow;
    endtask

    task automatic send_stop();
        @(negedge clk);
        stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
    endtask

    task automatic power_up();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic mem_write(input logic [7:0] a, input logic exp_data, input string tag);
        logic ad, aa, ak, wr;
        send_dev(MEMC, PIN, 1'b0, 1'b0, ad);
        check({tag, " dev ack"}, ad, 1);
        send_addr(a, aa);
        check("R11 word address ack", aa, 1);
        send_data(ak, wr);
        check({tag, " data ack"}, ak, exp_data);
        check({tag, " write allowed"}, wr, exp_data);
        send_stop();
    endtask

    task automatic prot_cmd(input logic [2:0] sel, input logic hv,
                            input logic exp_ack, input string tag);
        logic ad, aa, ak, wr;
        send_dev(PROTC, sel, 1'b0, hv, ad);
        check({tag, " cmd dev ack"}, ad, exp_ack);
        if (exp_ack) begin
            send_addr(8'h3C, aa);
            check({tag, " cmd addr ack"}, aa, 1);
            send_data(ak, wr);
            check({tag, " cmd data ack"}, ak, 1);
            check({tag, " cmd no array write"}, wr, 0);
        end
        send_stop();
    endtask

    task automatic query(input logic [2:0] sel, input logic hv,
                         input logic exp_ack, input string tag);
        logic ad;
        send_dev(PROTC, sel, 1'b1, hv, ad);
        check({tag, " query ack"}, ad, exp_ack);
        send_stop();
    endtask

    task automatic t_reset();
        check("R11 reset ack_dev", ack_dev, 0);
        check("R11 reset ack_addr", ack_addr, 0);
        check("R11 reset ack_data", ack_data, 0);
        check("R11 reset wr_allow", wr_allow, 0);
    endtask

    task automatic t_select();
        logic a;
        send_dev(MEMC, PIN, 1'b1, 1'b0, a);
        check("R1 matching select", a, 1);
        @(negedge clk);
        check("R11 ack is one pulse", ack_dev, 0);
        send_stop();
        send_dev(MEMC, 3'b001, 1'b0, 1'b0, a);
        check("R1 select mismatch", a, 0);
        send_stop();
        send_dev(4'b1111, PIN, 1'b0, 1'b0, a);
        check("R1 foreign code", a, 0);
        send_stop();
        send_dev(PROTC, 3'b100, 1'b0, 1'b0, a);
        check("R1 invalid protection select", a, 0);
        send_stop();
        mem_write(8'h10, 1'b1, "R1 plain low write");
        mem_write(8'hF0, 1'b1, "R1 plain high write");
    endtask

    task automatic t_wp();
        @(negedge clk); wp = 1'b1;
        mem_write(8'h90, 1'b0, "R2 wp high upper");
        mem_write(8'h20, 1'b0, "R2 wp high lower");
        prot_cmd(3'b000, 1'b1, 1'b0, "R3 set-reversible under wp");
        prot_cmd(3'b010, 1'b1, 1'b0, "R3 clear-reversible under wp");
        prot_cmd(PIN, 1'b0, 1'b0, "R3 set-permanent under wp");
        @(negedge clk); wp = 1'b0;
        mem_write(8'h20, 1'b1, "R3 lower still open after refused cmds");
    endtask

    task automatic t_rswp();
        prot_cmd(3'b000, 1'b1, 1'b1, "R4 set-reversible");
        mem_write(8'h05, 1'b0, "R4 lower protected");
        mem_write(8'h7F, 1'b0, "R4 top of lower half protected");
        mem_write(8'h80, 1'b1, "R4 upper half open");
        query(3'b000, 1'b1, 1'b0, "R8 reversible set");
        query(3'b010, 1'b1, 1'b0, "R8 reversible set (clear form)");
        query(PIN, 1'b0, 1'b1, "R8 permanent clear");
    endtask

    task automatic t_abandon();
        logic ad, aa;
        send_dev(PROTC, 3'b010, 1'b0, 1'b1, ad);
        check("R10 clear cmd dev ack", ad, 1);
        send_addr(8'h00, aa);
        check("R10 clear cmd addr ack", aa, 1);
        send_stop();
        mem_write(8'h05, 1'b0, "R10 abandoned clear kept protection");
    endtask

    task automatic t_cwp();
        prot_cmd(3'b010, 1'b1, 1'b1, "R5 clear-reversible");
        mem_write(8'h05, 1'b1, "R5 lower writable again");
        query(3'b000, 1'b1, 1'b1, "R8 reversible clear");
    endtask

    task automatic t_powerup();
        prot_cmd(3'b000, 1'b1, 1'b1, "R9 set-reversible before power-up");
        mem_write(8'h01, 1'b0, "R9 protected before power-up");
        power_up();
        mem_write(8'h01, 1'b1, "R9 reversible lost at power-up");
    endtask

    task automatic t_pswp();
        prot_cmd(PIN, 1'b0, 1'b1, "R6 set-permanent");
        mem_write(8'h00, 1'b0, "R6 lower protected");
        mem_write(8'hC3, 1'b1, "R6 upper open");
        prot_cmd(3'b010, 1'b1, 1'b0, "R7 clear refused");
        prot_cmd(3'b000, 1'b1, 1'b0, "R7 set-reversible refused");
        query(PIN, 1'b0, 1'b0, "R7 permanent query hidden");
        query(3'b000, 1'b1, 1'b0, "R7 reversible query hidden");
        @(negedge clk); wp = 1'b1;
        @(negedge clk); wp = 1'b0;
        mem_write(8'h40, 1'b0, "R6 survives wp toggle");
        power_up();
        mem_write(8'h40, 1'b0, "R6 survives power-up");
        mem_write(8'h41, 1'b0, "R9 permanent kept by power-up");
        @(negedge clk); nv_erase_n = 1'b0;
        @(negedge clk); nv_erase_n = 1'b1;
        mem_write(8'h40, 1'b1, "R9 erase clears permanent");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        nv_erase_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_wp();
        t_rswp();
        t_abandon();
        t_cwp();
        t_powerup();
        t_pswp();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule